// File: doc/BRIEF.md
# SPI Controller Event and Status Register

This block keeps the event and status word of an SPI controller that has a transmit queue and a receive queue. The shift engine gives it single-cycle strobes: a transfer start, a transfer end, a received word being pushed, and a transfer started by a remote master while the controller is a slave. It also sees both queue fill levels, the slave-select input and the mode bits. From these it keeps four sticky error and event flags and three live status flags. Software reads the word through a simple register bus at offset 0x24 and clears the sticky flags by writing ones.

The block also acts on protocol conditions. It blocks a receive push into a full queue. It asks for an all-ones filler word when a slave transfer starts and nothing is queued. It asks for the core to be disabled when another master drives slave-select while the controller is in master mode. It raises a combinational interrupt from the masked sticky flags.

Top module: `spi_evt_status`

## Requirements
- R1: Bit 31 (busy) is 1 from the clock edge after any start strobe (`xfer_start` or `slv_xfer_start`) until the clock edge after `xfer_done`. A start in the same cycle as a done keeps the bit at 1. Register writes never change bit 31.
- R2: `lst_cmd` arms a pending flag. The pending flag is cleared when `core_en` is 0, which takes precedence. It is also consumed when bit 14 fires, and a new `lst_cmd` in that same cycle keeps it armed. Bit 14 (last word) is set at the edge after an `xfer_done` for which the pending flag was already armed and `tx_level` is 0.
- R3: Bits 14, 12, 11 and 10 are sticky. A write of 1 to a bit at offset 0x24 clears it, and a write of 0 leaves it unchanged. When a set condition and a clearing write land in the same cycle, the bit ends up set.
- R4: When `rx_push` arrives while `rx_level` equals `RXQ_DEPTH`, `rx_accept` stays 0 in that cycle and bit 12 (overflow) is set at the next edge. In every other case `rx_accept` follows `rx_push`.
- R5: When `slv_xfer_start` arrives with `mode_master` at 0 and `tx_level` at 0, `tx_fill_ones` is 1 in that cycle and bit 11 (starved) is set at the next edge. In master mode neither happens.
- R6: `ssel_n` is active low and passes through a two-flop synchronizer. A falling edge of the synchronized line while `mode_master` is 1 pulses `core_dis_req` for one cycle, two edges after the input falls, and sets bit 10 (collision) at the following edge. Holding `ssel_n` low does not set bit 10 again after it has been cleared.
- R7: Bit 9 reads 1 exactly when `rx_level` was nonzero at the previous edge. Writes do not change it.
- R8: Bit 8 is loaded at each edge with `tx_level < TXQ_DEPTH` while `core_en` is 1, and holds its value while `core_en` is 0. Writes do not change it.
- R9: Reset clears the whole word to 0. Bits 30:15, 13 and 7:0 always read 0. `reg_rdata` is 0 when `reg_addr` is not 0x24.
- R10: `irq` is the OR of the sticky flags ANDed with `irq_mask`, where mask bit 0 gates bit 14, bit 1 gates bit 12, bit 2 gates bit 11 and bit 3 gates bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data; a 1 clears the matching sticky bit |
| reg_rdata | output | 32 | Status word when the address matches, else 0 |
| xfer_start | input | 1 | Shift engine began a transfer |
| xfer_done | input | 1 | Shift engine finished a transfer |
| rx_push | input | 1 | Received word offered to the receive queue |
| slv_xfer_start | input | 1 | Remote master began a transfer (slave mode) |
| tx_level | input | TX_LVL_W | Transmit queue occupancy |
| rx_level | input | RX_LVL_W | Receive queue occupancy |
| ssel_n | input | 1 | Asynchronous slave-select input, active low |
| core_en | input | 1 | Core enable mode bit |
| mode_master | input | 1 | 1 = master mode, 0 = slave mode |
| lst_cmd | input | 1 | Last-word command strobe |
| irq_mask | input | 4 | Interrupt enables for the sticky flags |
| rx_accept | output | 1 | Receive push may be written into the queue |
| tx_fill_ones | output | 1 | Shift engine must send an all-ones word |
| core_dis_req | output | 1 | Request to clear the core enable |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check on every cycle that overflowing pushes are refused, that filler and collision requests appear only in the correct mode and always leave their flag set, that the busy bit follows the start and done strobes, that the receive-not-empty bit tracks the level, that the transmit-not-full bit freezes while the core is disabled, and that reserved bits stay 0. Some behaviours only the bench scenarios can show: the set-over-clear priority in the same cycle, the arm-then-consume sequence of the last-word flag and its loss on disable, the falling-edge-only collision with a held select line, and write-0 and read-only immunity. These depend on multi-step histories that the bench drives as directed cases and then again under random traffic.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned NUM_STICKY = 4;

  // status word bit positions (software decodes these)
  localparam int unsigned POS_TIP = 31;
  localparam int unsigned POS_LT  = 14;
  localparam int unsigned POS_OV  = 12;
  localparam int unsigned POS_UN  = 11;
  localparam int unsigned POS_MME = 10;
  localparam int unsigned POS_NE  = 9;
  localparam int unsigned POS_NF  = 8;

  // sticky vector ordering, shared with irq_mask
  localparam int unsigned IDX_LT  = 0;
  localparam int unsigned IDX_OV  = 1;
  localparam int unsigned IDX_UN  = 2;
  localparam int unsigned IDX_MME = 3;

  localparam logic [WORD_W-1:0] RSVD_MASK = ~32'h8000_5F00;

  function automatic logic level_full(input int unsigned lvl, input int unsigned depth);
    return lvl >= depth;
  endfunction

  function automatic logic level_empty(input int unsigned lvl);
    return lvl == 0;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(
    input logic                  tip,
    input logic [NUM_STICKY-1:0] stk,
    input logic                  ne,
    input logic                  nf
  );
    logic [WORD_W-1:0] w;
    w          = '0;
    w[POS_TIP] = tip;
    w[POS_LT]  = stk[IDX_LT];
    w[POS_OV]  = stk[IDX_OV];
    w[POS_UN]  = stk[IDX_UN];
    w[POS_MME] = stk[IDX_MME];
    w[POS_NE]  = ne;
    w[POS_NF]  = nf;
    return w;
  endfunction

  function automatic logic [NUM_STICKY-1:0] w1c_mask(input logic [WORD_W-1:0] wd);
    logic [NUM_STICKY-1:0] m;
    m[IDX_LT]  = wd[POS_LT];
    m[IDX_OV]  = wd[POS_OV];
    m[IDX_UN]  = wd[POS_UN];
    m[IDX_MME] = wd[POS_MME];
    return m;
  endfunction

endpackage

// File: rtl/spi_evt_sync.sv
module spi_evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  output logic fall
);

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], sel_n};
  end

  assign fall = chain[STAGES] & ~chain[STAGES-1];

endmodule

// File: rtl/spi_evt_detect.sv
module spi_evt_detect
  import spi_evt_pkg::*;
#(
  parameter int unsigned TXQ_DEPTH = 8,
  parameter int unsigned RXQ_DEPTH = 8,
  parameter int unsigned TX_LVL_W  = $clog2(TXQ_DEPTH + 1),
  parameter int unsigned RX_LVL_W  = $clog2(RXQ_DEPTH + 1)
) (
  input  logic                  xfer_done,
  input  logic                  rx_push,
  input  logic                  slv_xfer_start,
  input  logic [TX_LVL_W-1:0]   tx_level,
  input  logic [RX_LVL_W-1:0]   rx_level,
  input  logic                  mode_master,
  input  logic                  sel_fall,
  input  logic                  last_armed,
  output logic [NUM_STICKY-1:0] ev_vec,
  output logic                  rx_accept,
  output logic                  tx_fill_ones,
  output logic                  core_dis_req
);

  logic tx_empty, rx_full;

  assign tx_empty = level_empty(32'(tx_level));
  assign rx_full  = level_full(32'(rx_level), RXQ_DEPTH);

  always_comb begin
    ev_vec          = '0;
    ev_vec[IDX_LT]  = xfer_done & last_armed & tx_empty;
    ev_vec[IDX_OV]  = rx_push & rx_full;
    ev_vec[IDX_UN]  = slv_xfer_start & ~mode_master & tx_empty;
    ev_vec[IDX_MME] = sel_fall & mode_master;
  end

  assign rx_accept    = rx_push & ~rx_full;
  assign tx_fill_ones = ev_vec[IDX_UN];
  assign core_dis_req = ev_vec[IDX_MME];

endmodule

// File: rtl/spi_evt_sticky.sv
module spi_evt_sticky #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q_r;
    // set has priority over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= 1'b0;
      else        q_r <= set_i[g] | (q_r & ~clr_i[g]);
    end
    assign q_o[g] = q_r;
  end

endmodule

// File: rtl/spi_evt_status.sv
module spi_evt_status
  import spi_evt_pkg::*;
#(
  parameter int unsigned TXQ_DEPTH   = 8,
  parameter int unsigned RXQ_DEPTH   = 8,
  parameter int unsigned TX_LVL_W    = $clog2(TXQ_DEPTH + 1),
  parameter int unsigned RX_LVL_W    = $clog2(RXQ_DEPTH + 1),
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned EVT_OFFSET  = 32'h24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [WORD_W-1:0]     reg_wdata,
  output logic [WORD_W-1:0]     reg_rdata,
  input  logic                  xfer_start,
  input  logic                  xfer_done,
  input  logic                  rx_push,
  input  logic                  slv_xfer_start,
  input  logic [TX_LVL_W-1:0]   tx_level,
  input  logic [RX_LVL_W-1:0]   rx_level,
  input  logic                  ssel_n,
  input  logic                  core_en,
  input  logic                  mode_master,
  input  logic                  lst_cmd,
  input  logic [NUM_STICKY-1:0] irq_mask,
  output logic                  rx_accept,
  output logic                  tx_fill_ones,
  output logic                  core_dis_req,
  output logic                  irq
);

  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(EVT_OFFSET);

  // named internal events, observed by the bound checker
  logic                  sel_fall;
  logic [NUM_STICKY-1:0] ev_vec;
  logic [NUM_STICKY-1:0] clr_vec;
  logic [NUM_STICKY-1:0] stk_q;
  logic                  addr_hit;
  logic                  wr_hit;
  logic                  start_any;
  logic                  tip_q, arm_q, ne_q, nf_q;
  logic [WORD_W-1:0]     stat_word;

  spi_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_n (ssel_n),
    .fall  (sel_fall)
  );

  spi_evt_detect #(
    .TXQ_DEPTH (TXQ_DEPTH),
    .RXQ_DEPTH (RXQ_DEPTH),
    .TX_LVL_W  (TX_LVL_W),
    .RX_LVL_W  (RX_LVL_W)
  ) u_det (
    .xfer_done      (xfer_done),
    .rx_push        (rx_push),
    .slv_xfer_start (slv_xfer_start),
    .tx_level       (tx_level),
    .rx_level       (rx_level),
    .mode_master    (mode_master),
    .sel_fall       (sel_fall),
    .last_armed     (arm_q),
    .ev_vec         (ev_vec),
    .rx_accept      (rx_accept),
    .tx_fill_ones   (tx_fill_ones),
    .core_dis_req   (core_dis_req)
  );

  assign addr_hit = (reg_addr == OFFS);
  assign wr_hit   = reg_wr & addr_hit;
  assign clr_vec  = wr_hit ? w1c_mask(reg_wdata) : '0;

  spi_evt_sticky #(.N(NUM_STICKY)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ev_vec),
    .clr_i (clr_vec),
    .q_o   (stk_q)
  );

  assign start_any = xfer_start | slv_xfer_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tip_q <= 1'b0;
      arm_q <= 1'b0;
      ne_q  <= 1'b0;
      nf_q  <= 1'b0;
    end else begin
      if (start_any)      tip_q <= 1'b1;
      else if (xfer_done) tip_q <= 1'b0;

      if (!core_en)                arm_q <= 1'b0;
      else if (lst_cmd)            arm_q <= 1'b1;
      else if (ev_vec[IDX_LT])     arm_q <= 1'b0;

      ne_q <= ~level_empty(32'(rx_level));

      if (core_en) nf_q <= ~level_full(32'(tx_level), TXQ_DEPTH);
    end
  end

  assign stat_word = pack_status(tip_q, stk_q, ne_q, nf_q);
  assign reg_rdata = addr_hit ? stat_word : '0;
  assign irq       = |(stk_q & irq_mask);

endmodule

// File: rtl/spi_evt_status_chk.sv
module spi_evt_status_chk
  import spi_evt_pkg::*;
#(
  parameter int unsigned TXQ_DEPTH = 8,
  parameter int unsigned RXQ_DEPTH = 8,
  parameter int unsigned TX_LVL_W  = $clog2(TXQ_DEPTH + 1),
  parameter int unsigned RX_LVL_W  = $clog2(RXQ_DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  xfer_start,
  input logic                  xfer_done,
  input logic                  rx_push,
  input logic                  slv_xfer_start,
  input logic [TX_LVL_W-1:0]   tx_level,
  input logic [RX_LVL_W-1:0]   rx_level,
  input logic                  core_en,
  input logic                  mode_master,
  input logic [NUM_STICKY-1:0] irq_mask,
  input logic [NUM_STICKY-1:0] ev_vec,
  input logic [WORD_W-1:0]     stat_word,
  input logic [WORD_W-1:0]     reg_rdata,
  input logic                  rx_accept,
  input logic                  tx_fill_ones,
  input logic                  core_dis_req,
  input logic                  irq
);

  AST_TIP_START: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start || slv_xfer_start) |=> stat_word[POS_TIP]); // R1

  AST_TIP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !xfer_start && !slv_xfer_start) |=> !stat_word[POS_TIP]); // R1

  AST_LT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_word[POS_LT]) |-> ($past(xfer_done) && $past(tx_level) == '0)); // R2

  AST_OV_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vec[IDX_OV] |=> stat_word[POS_OV]); // R3

  AST_OV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && 32'(rx_level) >= RXQ_DEPTH) |-> !rx_accept); // R4

  AST_OV_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && 32'(rx_level) < RXQ_DEPTH) |-> rx_accept); // R4

  AST_UN_SLAVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fill_ones |-> !mode_master); // R5

  AST_UN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fill_ones |=> stat_word[POS_UN]); // R5

  AST_MME_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    core_dis_req |-> mode_master); // R6

  AST_MME_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    core_dis_req |=> stat_word[POS_MME]); // R6

  AST_NE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stat_word[POS_NE] == ($past(rx_level) != '0))); // R7

  AST_NF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(core_en)) |-> $stable(stat_word[POS_NF])); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & RSVD_MASK) == '0); // R9

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_word[POS_LT] || stat_word[POS_OV] || stat_word[POS_UN] || stat_word[POS_MME])); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq); // R10

endmodule

bind spi_evt_status spi_evt_status_chk #(
  .TXQ_DEPTH (TXQ_DEPTH),
  .RXQ_DEPTH (RXQ_DEPTH),
  .TX_LVL_W  (TX_LVL_W),
  .RX_LVL_W  (RX_LVL_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .xfer_start     (xfer_start),
  .xfer_done      (xfer_done),
  .rx_push        (rx_push),
  .slv_xfer_start (slv_xfer_start),
  .tx_level       (tx_level),
  .rx_level       (rx_level),
  .core_en        (core_en),
  .mode_master    (mode_master),
  .irq_mask       (irq_mask),
  .ev_vec         (ev_vec),
  .stat_word      (stat_word),
  .reg_rdata      (reg_rdata),
  .rx_accept      (rx_accept),
  .tx_fill_ones   (tx_fill_ones),
  .core_dis_req   (core_dis_req),
  .irq            (irq)
);

// File: tb/tb_spi_evt_status.sv
`timescale 1ns/1ps
module tb_spi_evt_status;

  localparam int TXD = 8;
  localparam int RXD = 8;
  localparam logic [7:0] OFF = 8'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = OFF;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_start = 0, xfer_done = 0, rx_push = 0, slv_xfer_start = 0;
  logic [3:0]  tx_level = '0, rx_level = '0;
  logic        ssel_n = 1'b1, core_en = 1'b1, mode_master = 1'b1, lst_cmd = 1'b0;
  logic [3:0]  irq_mask = '0;
  logic        rx_accept, tx_fill_ones, core_dis_req, irq;

  always #5 clk = ~clk;

  spi_evt_status dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_start(xfer_start),
    .xfer_done(xfer_done), .rx_push(rx_push), .slv_xfer_start(slv_xfer_start),
    .tx_level(tx_level), .rx_level(rx_level), .ssel_n(ssel_n), .core_en(core_en),
    .mode_master(mode_master), .lst_cmd(lst_cmd), .irq_mask(irq_mask),
    .rx_accept(rx_accept), .tx_fill_ones(tx_fill_ones),
    .core_dis_req(core_dis_req), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench model state, from the requirements
  bit m_tip, m_lt, m_ov, m_un, m_mme, m_ne, m_nf, m_arm;
  bit m_s1 = 1, m_s2 = 1, m_s3 = 1;

  function automatic logic [31:0] model_word();
    logic [31:0] w = 32'h0;
    if (m_tip) w = w | 32'h8000_0000;
    if (m_lt)  w = w | 32'h0000_4000;
    if (m_ov)  w = w | 32'h0000_1000;
    if (m_un)  w = w | 32'h0000_0800;
    if (m_mme) w = w | 32'h0000_0400;
    if (m_ne)  w = w | 32'h0000_0200;
    if (m_nf)  w = w | 32'h0000_0100;
    return w;
  endfunction

  function automatic bit model_irq(input logic [3:0] msk);
    return (m_lt && msk[0]) || (m_ov && msk[1]) || (m_un && msk[2]) || (m_mme && msk[3]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: inputs are already applied just after a falling edge
  task automatic tick(input string tag);
    bit e_ov, e_un, e_mme, e_lt, wclr;
    bit [31:0] cm;
    #1;
    e_ov  = rx_push && (rx_level == RXD);
    e_un  = slv_xfer_start && !mode_master && (tx_level == 0);
    e_mme = m_s3 && !m_s2 && mode_master;
    e_lt  = xfer_done && m_arm && (tx_level == 0);
    chk("R4 rx_accept", {31'b0, rx_accept}, {31'b0, rx_push && !e_ov});
    chk("R5 tx_fill_ones", {31'b0, tx_fill_ones}, {31'b0, e_un});
    chk("R6 core_dis_req", {31'b0, core_dis_req}, {31'b0, e_mme});
    chk("R10 irq", {31'b0, irq}, {31'b0, model_irq(irq_mask)});
    wclr = reg_wr && (reg_addr == OFF);
    cm = wclr ? reg_wdata : 32'h0;
    m_lt  = e_lt  || (m_lt  && !cm[14]);
    m_ov  = e_ov  || (m_ov  && !cm[12]);
    m_un  = e_un  || (m_un  && !cm[11]);
    m_mme = e_mme || (m_mme && !cm[10]);
    if (xfer_start || slv_xfer_start) m_tip = 1;
    else if (xfer_done) m_tip = 0;
    if (!core_en) m_arm = 0;
    else if (lst_cmd) m_arm = 1;
    else if (e_lt) m_arm = 0;
    m_ne = (rx_level != 0);
    if (core_en) m_nf = (tx_level < TXD);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ssel_n;
    @(negedge clk);
    chk({tag, " word"}, reg_rdata, (reg_addr == OFF) ? model_word() : 32'h0);
    xfer_start = 0; xfer_done = 0; rx_push = 0; slv_xfer_start = 0;
    lst_cmd = 0; reg_wr = 0; reg_wdata = '0; reg_addr = OFF;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1; reg_addr = OFF; reg_wdata = d;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    // reset state, R9
    repeat (3) @(negedge clk);
    chk("R9 reset word", reg_rdata, 32'h0);
    chk("R10 reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1;

    // R1 busy bit
    xfer_start = 1; tick("R1");
    tick("R1");
    xfer_done = 1; xfer_start = 1; tick("R1");
    xfer_done = 1; tick("R1");
    wr(32'hFFFF_FFFF); tick("R1");

    // R2 last-word flag
    tx_level = 2; lst_cmd = 1; tick("R2");
    xfer_done = 1; tick("R2");
    tx_level = 0; xfer_done = 1; tick("R2");
    wr(32'h0); tick("R2");
    wr(32'h0000_4000); tick("R2");
    lst_cmd = 1; tick("R2");
    core_en = 0; tick("R2");
    core_en = 1; xfer_done = 1; tick("R2");

    // R3 set wins over same-cycle clear, R4 overflow
    rx_level = RXD; rx_push = 1; wr(32'h0000_1000); tick("R3");
    tick("R3");
    wr(32'h0000_1000); tick("R3");
    rx_level = RXD - 1; rx_push = 1; tick("R4");
    rx_level = RXD; rx_push = 1; tick("R4");
    wr(32'h0000_1000); tick("R4");

    // R5 starved slave start
    mode_master = 0; tx_level = 0; slv_xfer_start = 1; tick("R5");
    tx_level = 3; slv_xfer_start = 1; tick("R5");
    wr(32'h0000_0800); tick("R5");
    mode_master = 1; tx_level = 0; slv_xfer_start = 1; tick("R5");

    // R6 collision, held low does not retrigger
    ssel_n = 0;
    repeat (4) tick("R6");
    wr(32'h0000_0400); tick("R6");
    repeat (4) tick("R6");
    ssel_n = 1; repeat (3) tick("R6");
    mode_master = 0; ssel_n = 0; repeat (4) tick("R6");
    ssel_n = 1; mode_master = 1; repeat (3) tick("R6");

    // R7 / R8 live flags, R9 decode
    rx_level = 5; tick("R7");
    rx_level = 0; tick("R7");
    tx_level = TXD; tick("R8");
    core_en = 0; tx_level = 1; tick("R8");
    tick("R8");
    core_en = 1; tick("R8");
    reg_addr = 8'h20; tick("R9");
    wr(32'hFFFF_FFFF); tick("R9");

    // R10 masks
    rx_level = RXD; rx_push = 1; tick("R10");
    for (int k = 0; k < 16; k++) begin
      irq_mask = 4'(k); tick("R10");
    end

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      xfer_start     = ($urandom % 6) == 0;
      xfer_done      = ($urandom % 5) == 0;
      rx_push        = ($urandom % 3) == 0;
      slv_xfer_start = ($urandom % 8) == 0;
      lst_cmd        = ($urandom % 7) == 0;
      r = $urandom % 4;
      tx_level = (r == 0) ? 4'd0 : (r == 1) ? 4'(TXD) : 4'($urandom % (TXD + 1));
      r = $urandom % 4;
      rx_level = (r == 0) ? 4'd0 : (r == 1) ? 4'(RXD) : 4'($urandom % (RXD + 1));
      if (($urandom % 10) == 0) ssel_n = ~ssel_n;
      if (($urandom % 20) == 0) mode_master = ~mode_master;
      core_en  = ($urandom % 12) != 0;
      irq_mask = 4'($urandom);
      if (($urandom % 5) == 0) begin
        reg_wr = 1; reg_wdata = $urandom;
      end
      reg_addr = (($urandom % 16) == 0) ? 8'($urandom) : OFF;
      tick("R3 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule